// File: doc/BRIEF.md
# Unlock-Sequence Store Command Sequencer

This block sits beside a shadow-backed RAM and watches completed bus cycles for a protected command. A command is entered as three pseudo-write cycles made while the nonvolatile-select line is active. The first two cycles carry fixed key pairs. The third carries a command byte. That byte can ask for an immediate store of the RAM into the shadow array, arm automatic power-fail storing, or disarm it. The array transfer and the supply monitor are built elsewhere. This block only produces the single-clock store request and the automatic-store enable.

A second layer of protection stops a store from ever copying an untouched RAM over the shadow contents. A sticky flag records whether any ordinary RAM write has happened since reset. A store request is issued only while that flag is set. The `auto_armed` output, which is the enable qualified by the same flag, is what the power-fail logic should use. The flag is cleared only by the power-on reset (`rst_n`), and that reset also clears the enable, so the block always starts disarmed.

The sequencer has three states. The state `SEQ_IDLE` waits for key one. The state `SEQ_KEY1` has seen key one and waits for key two. The state `SEQ_KEY2` has seen both keys and waits for the command. Its transitions are:
- idle to key1 on a key-one cycle;
- key1 to key2 on a key-two cycle;
- key1 to idle on any other command cycle;
- key2 to idle on every command cycle, acting only when that cycle carries a known command at the step-three address;
- every state holds on cycles that are not command cycles.

Top module: `nvs_cmd_seq`

## Requirements
- R1: A bus cycle (one clock with `cyc_stb`=1) counts as a command cycle only when `ce_n`, `we_n` and `nv_n` are all 0. Any other cycle never advances or resets the sequence.
- R2: The sequence is address 0x155 with data 0xAA, then address 0x0AA with data 0x55, then address 0x155 carrying the command byte in `data`.
- R3: Command byte 0x33 raises `store_req` for exactly one clock. That clock is the one after the third step cycle.
- R4: Command byte 0xCC sets `auto_en` and 0xCD clears it. Either change is visible from the clock after the third step cycle.
- R5: A store command made before any RAM write since reset produces no `store_req`. `auto_armed` is 1 only when `auto_en` is 1 and a RAM write has been seen.
- R6: A command cycle that does not match the expected key pair returns the sequencer to idle. A fresh key-one cycle afterwards starts a new sequence.
- R7: In the third step, an unknown command byte or an address other than 0x155 has no effect on any output, and the sequencer returns to idle.
- R8: While `rst_n` is 0 and after it, until a command acts, `store_req`=0 and `auto_en`=0. The write-seen flag is cleared and the sequencer is idle.
- R9: A RAM write is a cycle with `ce_n`=0, `we_n`=0 and `nv_n`=1. RAM reads and writes placed between the steps leave the sequence intact.
- R10: The write-seen flag stays set across any number of later stores and commands until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cyc_stb | input | 1 | Marks the clock in which a bus cycle completes |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| nv_n | input | 1 | Nonvolatile select, active low |
| addr | input | 9 | Cycle address |
| data | input | 8 | Cycle write data |
| store_req | output | 1 | One-clock request to copy the RAM into the shadow array |
| auto_en | output | 1 | Automatic power-fail store enable |
| auto_armed | output | 1 | Enable qualified by the write-seen flag |

## Verification
Some properties are checked on every cycle:
- non-command cycles never move the sequencer;
- the key-two state is entered only from the key-one state;
- `store_req` never lasts two clocks and never appears without a prior RAM write;
- the write-seen flag never falls outside reset;
- `auto_en` changes only in the clock after a decoded enable or disable command.

Other behaviour shows only in the bench's scenarios:
- that the exact key values and command bytes are the ones decoded;
- that a mismatch or unknown byte is harmless and that a restart after it succeeds;
- that interleaved RAM traffic is tolerated;
- that reset disarms a latch that was previously set.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_KEY1 = 2'd1,
        SEQ_KEY2 = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        ACT_NONE     = 2'd0,
        ACT_STORE    = 2'd1,
        ACT_AUTO_ON  = 2'd2,
        ACT_AUTO_OFF = 2'd3
    } seq_act_t;
endpackage

// File: rtl/nvs_cycle_decode.sv
module nvs_cycle_decode (
    input  logic cyc_stb,
    input  logic ce_n,
    input  logic we_n,
    input  logic nv_n,
    output logic cmd_cyc,
    output logic ram_wr
);
    // R1: command cycle needs all three strobes low
    assign cmd_cyc = cyc_stb && !ce_n && !we_n && !nv_n;
    // R9: ordinary RAM write keeps nonvolatile select high
    assign ram_wr  = cyc_stb && !ce_n && !we_n && nv_n;
endmodule

// File: rtl/nvs_seq_fsm.sv
module nvs_seq_fsm
    import nvs_pkg::*;
#(
    parameter int            AW        = 9,
    parameter int            DW        = 8,
    parameter logic [AW-1:0] KEY_ADDR1 = 9'h155,
    parameter logic [DW-1:0] KEY_DATA1 = 8'hAA,
    parameter logic [AW-1:0] KEY_ADDR2 = 9'h0AA,
    parameter logic [DW-1:0] KEY_DATA2 = 8'h55,
    parameter logic [DW-1:0] CMD_STORE = 8'h33,
    parameter logic [DW-1:0] CMD_AON   = 8'hCC,
    parameter logic [DW-1:0] CMD_AOFF  = 8'hCD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_cyc,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output seq_act_t      act
);
    seq_state_t state, state_nx;
    logic       hit1, hit2, at3;

    assign hit1 = (addr == KEY_ADDR1) && (data == KEY_DATA1);
    assign hit2 = (addr == KEY_ADDR2) && (data == KEY_DATA2);
    assign at3  = (addr == KEY_ADDR1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        act      = ACT_NONE;
        unique case (state)
            SEQ_IDLE: if (cmd_cyc && hit1) state_nx = SEQ_KEY1;
            SEQ_KEY1: if (cmd_cyc) state_nx = hit2 ? SEQ_KEY2 : SEQ_IDLE;
            SEQ_KEY2: begin
                if (cmd_cyc) begin
                    state_nx = SEQ_IDLE;
                    if (at3) begin
                        if      (data == CMD_STORE) act = ACT_STORE;
                        else if (data == CMD_AON)   act = ACT_AUTO_ON;
                        else if (data == CMD_AOFF)  act = ACT_AUTO_OFF;
                    end
                end
            end
            default: state_nx = SEQ_IDLE;
        endcase
    end

    // R1, R9: only command cycles move the sequencer
    a_r1_hold_off_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_cyc |=> $stable(state));
    // R2: key-two state is reached only from key-one state
    a_r2_key2_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_KEY2 && $past(state) != SEQ_KEY2) |-> $past(state) == SEQ_KEY1);
    // R6: a command cycle in key2 always ends the sequence
    a_r6_key2_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_KEY2 && cmd_cyc) |=> state == SEQ_IDLE);
endmodule

// File: rtl/nvs_guard.sv
module nvs_guard
    import nvs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ram_wr,
    input  seq_act_t act,
    output logic     store_req,
    output logic     auto_en,
    output logic     wr_seen
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_seen   <= 1'b0;
            store_req <= 1'b0;
            auto_en   <= 1'b0;
        end else begin
            wr_seen   <= wr_seen | ram_wr;
            store_req <= (act == ACT_STORE) && wr_seen;
            if (act == ACT_AUTO_ON)       auto_en <= 1'b1;
            else if (act == ACT_AUTO_OFF) auto_en <= 1'b0;
        end
    end

    // R3: request is a single-clock pulse
    a_r3_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> !store_req);
    // R5: no request without a prior RAM write
    a_r5_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> wr_seen);
    // R10: write-seen flag is sticky
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wr_seen |=> wr_seen);
    // R4: enable moves only after an enable/disable command
    a_r4_en_source: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(auto_en) |-> ($past(act) == ACT_AUTO_ON || $past(act) == ACT_AUTO_OFF));
endmodule

// File: rtl/nvs_cmd_seq.sv
module nvs_cmd_seq
    import nvs_pkg::*;
#(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_stb,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          nv_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          store_req,
    output logic          auto_en,
    output logic          auto_armed
);
    logic     cmd_cyc, ram_wr, wr_seen;
    seq_act_t act;

    nvs_cycle_decode u_dec (
        .cyc_stb (cyc_stb),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .nv_n    (nv_n),
        .cmd_cyc (cmd_cyc),
        .ram_wr  (ram_wr)
    );

    nvs_seq_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_cyc (cmd_cyc),
        .addr    (addr),
        .data    (data),
        .act     (act)
    );

    nvs_guard u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .ram_wr    (ram_wr),
        .act       (act),
        .store_req (store_req),
        .auto_en   (auto_en),
        .wr_seen   (wr_seen)
    );

    // R5: armed output qualified by write history
    assign auto_armed = auto_en && wr_seen;
endmodule

// File: tb/nvs_cmd_seq_test.sv
`timescale 1ns/1ps
module nvs_cmd_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_stb = 1'b0;
    logic       ce_n = 1'b1, we_n = 1'b1, nv_n = 1'b1;
    logic [8:0] addr = '0;
    logic [7:0] data = '0;
    logic       store_req, auto_en, auto_armed;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    nvs_cmd_seq uut (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb),
        .ce_n(ce_n), .we_n(we_n), .nv_n(nv_n),
        .addr(addr), .data(data),
        .store_req(store_req), .auto_en(auto_en), .auto_armed(auto_armed)
    );

    // entry: {ce_n,we_n,nv_n, addr, data, exp store, exp auto_en, exp armed}
    localparam int NV = 39;
    localparam logic [22:0] VEC [NV] = '{
        {3'b000, 9'h155, 8'hAA, 3'b000},  // 0  key1
        {3'b000, 9'h0AA, 8'h55, 3'b000},  // 1  key2
        {3'b000, 9'h155, 8'h33, 3'b000},  // 2  R5 store before any write
        {3'b001, 9'h010, 8'h5A, 3'b000},  // 3  R9 RAM write
        {3'b000, 9'h155, 8'hAA, 3'b000},  // 4
        {3'b000, 9'h0AA, 8'h55, 3'b000},  // 5
        {3'b000, 9'h155, 8'h33, 3'b100},  // 6  R3 store
        {3'b000, 9'h155, 8'hAA, 3'b000},  // 7
        {3'b000, 9'h0AA, 8'h55, 3'b000},  // 8
        {3'b000, 9'h155, 8'hCC, 3'b011},  // 9  R4 enable
        {3'b000, 9'h155, 8'hAA, 3'b011},  // 10
        {3'b000, 9'h0AA, 8'h56, 3'b011},  // 11 R6 bad key2
        {3'b000, 9'h155, 8'hCD, 3'b011},  // 12 R6 no effect from idle
        {3'b000, 9'h155, 8'hAA, 3'b011},  // 13
        {3'b000, 9'h0AA, 8'h55, 3'b011},  // 14
        {3'b000, 9'h155, 8'hCD, 3'b000},  // 15 R4 disable
        {3'b000, 9'h155, 8'hAA, 3'b000},  // 16
        {3'b011, 9'h020, 8'h00, 3'b000},  // 17 R9 RAM read between steps
        {3'b001, 9'h021, 8'h11, 3'b000},  // 18 R9 RAM write between steps
        {3'b000, 9'h0AA, 8'h55, 3'b000},  // 19
        {3'b000, 9'h155, 8'h33, 3'b100},  // 20 R9/R10 store still works
        {3'b000, 9'h155, 8'hAA, 3'b000},  // 21
        {3'b000, 9'h0AA, 8'h55, 3'b000},  // 22
        {3'b000, 9'h155, 8'h77, 3'b000},  // 23 R7 unknown byte
        {3'b000, 9'h0AA, 8'h55, 3'b000},  // 24 idle again
        {3'b000, 9'h155, 8'h33, 3'b000},  // 25 R7 back in idle
        {3'b100, 9'h155, 8'hAA, 3'b000},  // 26 R1 ce_n high
        {3'b000, 9'h0AA, 8'h55, 3'b000},  // 27
        {3'b000, 9'h155, 8'h33, 3'b000},  // 28 R1 no store
        {3'b000, 9'h155, 8'hAA, 3'b000},  // 29
        {3'b000, 9'h0AA, 8'h55, 3'b000},  // 30
        {3'b000, 9'h0AA, 8'h33, 3'b000},  // 31 R7 wrong step3 address
        {3'b000, 9'h155, 8'hAA, 3'b000},  // 32
        {3'b000, 9'h155, 8'hAA, 3'b000},  // 33 R6 key1 in key1 state
        {3'b000, 9'h0AA, 8'h55, 3'b000},  // 34
        {3'b000, 9'h155, 8'hCC, 3'b000},  // 35 R6 no enable
        {3'b000, 9'h155, 8'hAA, 3'b000},  // 36 R6 restart
        {3'b000, 9'h0AA, 8'h55, 3'b000},  // 37
        {3'b000, 9'h155, 8'hCC, 3'b011}   // 38 R6 enable after restart
    };

    task automatic chk(input string req, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // one bus cycle: strobe for one clock, then sample after the edge
    task automatic bus(input logic c, input logic w, input logic n,
                       input logic [8:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = c; we_n = w; nv_n = n; addr = a; data = d; cyc_stb = 1'b1;
        @(negedge clk);
        cyc_stb = 1'b0; ce_n = 1'b1; we_n = 1'b1; nv_n = 1'b1;
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 store_req in reset", store_req, 1'b0);
        chk("R8 auto_en in reset", auto_en, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 auto_armed after reset", auto_armed, 1'b0);

        for (int i = 0; i < NV; i++) begin
            bus(VEC[i][22], VEC[i][21], VEC[i][20], VEC[i][19:11], VEC[i][10:3]);
            chk($sformatf("R2 vec%0d store_req", i), store_req, VEC[i][2]);
            chk($sformatf("R4 vec%0d auto_en", i), auto_en, VEC[i][1]);
            chk($sformatf("R5 vec%0d auto_armed", i), auto_armed, VEC[i][0]);
        end

        // R3: pulse is exactly one clock wide
        bus(3'b0, 1'b0, 1'b0, 9'h155, 8'hAA);
        bus(1'b0, 1'b0, 1'b0, 9'h0AA, 8'h55);
        bus(1'b0, 1'b0, 1'b0, 9'h155, 8'h33);
        chk("R3 pulse high", store_req, 1'b1);
        @(negedge clk);
        chk("R3 pulse low next clock", store_req, 1'b0);

        // R8: reset clears the enable and the write history
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 auto_en cleared by reset", auto_en, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        bus(1'b0, 1'b0, 1'b0, 9'h155, 8'hAA);
        bus(1'b0, 1'b0, 1'b0, 9'h0AA, 8'h55);
        bus(1'b0, 1'b0, 1'b0, 9'h155, 8'hCC);
        chk("R4 enable without write", auto_en, 1'b1);
        chk("R5 not armed without write", auto_armed, 1'b0);
        bus(1'b0, 1'b0, 1'b0, 9'h155, 8'hAA);
        bus(1'b0, 1'b0, 1'b0, 9'h0AA, 8'h55);
        bus(1'b0, 1'b0, 1'b0, 9'h155, 8'h33);
        chk("R8 write history cleared by reset", store_req, 1'b0);
        bus(1'b0, 1'b0, 1'b1, 9'h1FF, 8'h00);
        chk("R10 armed after write", auto_armed, 1'b1);
        for (int k = 0; k < 2; k++) begin
            bus(1'b0, 1'b0, 1'b0, 9'h155, 8'hAA);
            bus(1'b0, 1'b0, 1'b0, 9'h0AA, 8'h55);
            bus(1'b0, 1'b0, 1'b0, 9'h155, 8'h33);
            chk("R10 repeated store", store_req, 1'b1);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule